// File: doc/BRIEF.md
# DMA Bus Hand-Over Arbiter

This block sits on the processor side of a shared system bus and decides when an external DMA master may take the bus. A device raises a request. The arbiter waits until any processor bus cycle that is already running has finished. It then raises grant, holds the processor so that no new cycle starts, and drops the enable of the processor's address, data and strobe drivers so that they float.

The device confirms the hand-over with a grant-acknowledge, and the tenure is then active. During the tenure, every write strobe the device drives on the bus produces a one-clock snoop report carrying the write address. A cache next to the processor uses that report to invalidate or update a copy it may hold. The device ends its tenure with a release level. The arbiter answers with a release-acknowledge, holds it until the release level falls, and then hands the bus back to the processor, which carries on from where it was held.

The snoop report is a plain pulse and has no back-pressure. The consumer must take a report in the same cycle it appears, because the device write it describes cannot be stalled. If a request is withdrawn before it is acknowledged, the arbiter retracts the grant.

Top module: `dma_bus_arbiter`

## Requirements
- R1: After reset, grant, release-acknowledge, hold and snoop valid are all 0, and the processor driver enable is 1.
- R2: Grant is never raised while the processor reports a bus cycle in progress. It rises one clock after the first edge at which the request is high and the busy input is low, counted from the clock after the request was first sampled.
- R3: Hold is 1 from the clock after a request is sampled until the arbiter returns to idle, and it is 1 whenever grant is 1.
- R4: The processor driver enable is 0 from the clock grant rises until release-acknowledge falls. Outside that span it is 1, and this includes the wait for the processor cycle to end.
- R5: If the request is low at an edge while grant is waiting for acknowledge, grant, hold and release-acknowledge are all 0 one clock later, and the driver enable returns to 1.
- R6: Grant-acknowledge or release has no effect unless it arrives in the state that expects it. While idle, either input leaves every output at its reset value.
- R7: During an acknowledged tenure, a rising edge of the device write strobe produces snoop valid for exactly one clock, starting one clock later. The snoop address equals the device address sampled at that edge and stays stable until the next report.
- R8: A write strobe seen while idle, while waiting, or while granted but not yet acknowledged produces no snoop valid.
- R9: A release sampled during the tenure drops grant and raises release-acknowledge one clock later. Release-acknowledge stays high while release is high. One clock after release is sampled low, the arbiter is idle again, with the driver enable restored and hold removed.
- R10: A write strobe held high for several clocks gives a single snoop pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_cycle_busy | input | 1 | Processor bus cycle in progress |
| dma_req | input | 1 | Bus request from the DMA device |
| dma_gnt_ack | input | 1 | Device acknowledges the grant |
| dma_release | input | 1 | Device gives the bus back (level) |
| dev_wr_strobe | input | 1 | Device write strobe on the bus |
| dev_addr | input | ADDR_W | Device address on the bus |
| dma_gnt | output | 1 | Bus granted to the device |
| dma_rel_ack | output | 1 | Release acknowledged |
| cpu_hold | output | 1 | Processor must not start a new bus cycle |
| cpu_bus_oe | output | 1 | Processor address, data and strobe driver enable |
| snoop_valid | output | 1 | One-clock report of a device write |
| snoop_addr | output | ADDR_W | Address of the reported write |

## Verification
Directed sequences try the hand-over under a long processor busy stretch, which separates a grant that waits for the cycle to end from one that grants early. They also cover a request dropped before acknowledge, and acknowledge or strobes arriving in states that must ignore them. A held strobe and a later second strobe with a new address separate edge detection from level detection and show whether the snoop address is captured or passed through. Seeded random toggling of every input, with requests that rarely change and long release levels, reaches state and input combinations the directed cases miss. Each clock is checked against a cycle model in the bench.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_WAIT_END = 3'd1,
    ST_GRANTED  = 3'd2,
    ST_ACTIVE   = 3'd3,
    ST_REL_ACK  = 3'd4
  } arb_state_e;

endpackage

// File: rtl/dma_arb_fsm.sv
module dma_arb_fsm
  import dma_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_i,
  input  logic       busy_i,
  input  logic       gnt_ack_i,
  input  logic       release_i,
  output arb_state_e state_o,
  output logic       gnt_o,
  output logic       rel_ack_o,
  output logic       hold_o,
  output logic       oe_o,
  output logic       tenure_o
);

  arb_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (req_i) state_d = ST_WAIT_END;
      ST_WAIT_END: begin
        if (!req_i)       state_d = ST_IDLE;
        else if (!busy_i) state_d = ST_GRANTED;
      end
      ST_GRANTED: begin
        if (!req_i)         state_d = ST_IDLE;
        else if (gnt_ack_i) state_d = ST_ACTIVE;
      end
      ST_ACTIVE:   if (release_i)  state_d = ST_REL_ACK;
      ST_REL_ACK:  if (!release_i) state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state_o   = state_q;
  assign gnt_o     = (state_q == ST_GRANTED) || (state_q == ST_ACTIVE);
  assign rel_ack_o = (state_q == ST_REL_ACK);
  assign hold_o    = (state_q != ST_IDLE);
  assign oe_o      = (state_q == ST_IDLE) || (state_q == ST_WAIT_END);
  assign tenure_o  = (state_q == ST_ACTIVE);

  // R5: an unacknowledged grant with the request gone falls back to idle
  assert_grant_withdraw_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_GRANTED && !req_i) |=> (state_q == ST_IDLE));

  // R9: release during tenure leads straight to the acknowledge phase
  assert_release_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACTIVE && release_i) |=> (rel_ack_o && !gnt_o));

  // R6: the tenure is only ever entered from the granted state
  assert_tenure_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tenure_o) |-> ($past(state_q) == ST_GRANTED));

endmodule

// File: rtl/dma_snoop_capture.sv
module dma_snoop_capture #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o
);

  logic wr_q;
  logic take;

  assign take = enable_i && wr_i && !wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      valid_o <= 1'b0;
      addr_o  <= '0;
    end else begin
      wr_q    <= wr_i;
      valid_o <= take;
      if (take) addr_o <= addr_i;
    end
  end

  // R10: a report never lasts two clocks
  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  // R8: reports only follow strobes seen inside an acknowledged tenure
  assert_snoop_in_tenure_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_o) |-> $past(enable_i && wr_i));

  // R7: the reported address stays put between reports
  assert_addr_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> $stable(addr_o));

endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter
  import dma_arb_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_cycle_busy,
  input  logic              dma_req,
  input  logic              dma_gnt_ack,
  input  logic              dma_release,
  input  logic              dev_wr_strobe,
  input  logic [ADDR_W-1:0] dev_addr,
  output logic              dma_gnt,
  output logic              dma_rel_ack,
  output logic              cpu_hold,
  output logic              cpu_bus_oe,
  output logic              snoop_valid,
  output logic [ADDR_W-1:0] snoop_addr
);

  arb_state_e state;
  logic       tenure;

  dma_arb_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (dma_req),
    .busy_i    (cpu_cycle_busy),
    .gnt_ack_i (dma_gnt_ack),
    .release_i (dma_release),
    .state_o   (state),
    .gnt_o     (dma_gnt),
    .rel_ack_o (dma_rel_ack),
    .hold_o    (cpu_hold),
    .oe_o      (cpu_bus_oe),
    .tenure_o  (tenure)
  );

  dma_snoop_capture #(.ADDR_W(ADDR_W)) u_snoop (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable_i (tenure),
    .wr_i     (dev_wr_strobe),
    .addr_i   (dev_addr),
    .valid_o  (snoop_valid),
    .addr_o   (snoop_addr)
  );

  // R2: grant rises only after an edge that saw the processor idle
  assert_grant_after_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_gnt) |-> $past(!cpu_cycle_busy && dma_req));

  // R3: the processor is held whenever the device owns the bus
  assert_hold_during_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_gnt || dma_rel_ack) |-> cpu_hold);

  // R4: processor drivers stay floated while the bus is handed over
  assert_drivers_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_gnt || dma_rel_ack) |-> !cpu_bus_oe);

  // R9: leaving release-acknowledge returns control to the processor
  assert_return_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dma_rel_ack) |-> (cpu_bus_oe && !cpu_hold && state == ST_IDLE));

endmodule

// File: tb/tb_dma_bus_arbiter.sv
module tb_dma_bus_arbiter;

  localparam int AW = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n, busy, req, ack, rel, strb;
  logic [AW-1:0] addr;
  logic          gnt, rel_ack, hold, oe, sv;
  logic [AW-1:0] sa;

  dma_bus_arbiter #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_cycle_busy(busy), .dma_req(req),
    .dma_gnt_ack(ack), .dma_release(rel), .dev_wr_strobe(strb), .dev_addr(addr),
    .dma_gnt(gnt), .dma_rel_ack(rel_ack), .cpu_hold(hold), .cpu_bus_oe(oe),
    .snoop_valid(sv), .snoop_addr(sa)
  );

  int vectors = 0;
  int miscompares = 0;

  // cycle model: 0 idle, 1 wait-end, 2 granted, 3 active, 4 release-ack
  int            m_st = 0;
  logic          m_wrq = 1'b0, m_sv = 1'b0;
  logic [AW-1:0] m_sa = '0;

  function automatic int next_st(int s, logic rq, logic bz, logic ak, logic rl);
    case (s)
      0: return rq ? 1 : 0;
      1: return !rq ? 0 : (!bz ? 2 : 1);
      2: return !rq ? 0 : (ak ? 3 : 2);
      3: return rl ? 4 : 3;
      default: return rl ? 4 : 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_wrq = 1'b0; m_sv = 1'b0; m_sa = '0;
    end else begin
      m_sv = (m_st == 3) && strb && !m_wrq;
      if (m_sv) m_sa = addr;
      m_wrq = strb;
      m_st = next_st(m_st, req, busy, ack, rel);
    end
  end

  task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", rq, what, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R2", "dma_gnt", 32'(gnt), 32'(m_st == 2 || m_st == 3));
    chk("R9", "dma_rel_ack", 32'(rel_ack), 32'(m_st == 4));
    chk("R3", "cpu_hold", 32'(hold), 32'(m_st != 0));
    chk("R4", "cpu_bus_oe", 32'(oe), 32'(m_st <= 1));
    chk("R7", "snoop_valid", 32'(sv), 32'(m_sv));
    chk("R7", "snoop_addr", 32'(sa), 32'(m_sa));
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    check_all();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired, actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    rst_n = 1'b0; busy = 1'b0; req = 1'b0; ack = 1'b0; rel = 1'b0;
    strb = 1'b0; addr = '0;
    step(); step();
    // R1: reset values
    chk("R1", "gnt", 32'(gnt), 0); chk("R1", "oe", 32'(oe), 1);
    chk("R1", "hold", 32'(hold), 0); chk("R1", "snoop", 32'(sv), 0);
    chk("R1", "rel_ack", 32'(rel_ack), 0);
    rst_n = 1'b1;
    step();

    // R6: acknowledge and release while idle are ignored
    ack = 1'b1; rel = 1'b1; step(); step();
    chk("R6", "gnt", 32'(gnt), 0); chk("R6", "rel_ack", 32'(rel_ack), 0);
    chk("R6", "hold", 32'(hold), 0);
    ack = 1'b0; rel = 1'b0;

    // R2: no grant while the processor cycle is running
    busy = 1'b1; req = 1'b1;
    step(); chk("R3", "hold", 32'(hold), 1); chk("R4", "oe_wait", 32'(oe), 1);
    step(); step(); chk("R2", "gnt_busy", 32'(gnt), 0);
    busy = 1'b0; step(); chk("R2", "gnt_after", 32'(gnt), 1);
    chk("R4", "oe_gnt", 32'(oe), 0);

    // R8: strobe before acknowledge is not reported
    strb = 1'b1; addr = 16'h1234; step(); step();
    chk("R8", "snoop", 32'(sv), 0);
    strb = 1'b0;

    // R5: request withdrawn before acknowledge
    req = 1'b0; step();
    chk("R5", "gnt", 32'(gnt), 0); chk("R5", "oe", 32'(oe), 1);
    chk("R5", "hold", 32'(hold), 0);

    // full tenure with snoops
    req = 1'b1; step(); step(); ack = 1'b1; step(); ack = 1'b0;
    strb = 1'b1; addr = 16'hBEEF; step();
    chk("R7", "valid", 32'(sv), 1); chk("R7", "addr", 32'(sa), 32'h0000BEEF);
    addr = 16'h0F0F; step();
    chk("R10", "valid_held", 32'(sv), 0); chk("R7", "addr_stable", 32'(sa), 32'h0000BEEF);
    step(); chk("R10", "valid_held2", 32'(sv), 0);
    strb = 1'b0; step();
    strb = 1'b1; addr = 16'h8001; step();
    chk("R7", "valid2", 32'(sv), 1); chk("R7", "addr2", 32'(sa), 32'h00008001);
    strb = 1'b0;
    rel = 1'b1; req = 1'b0; step();
    chk("R9", "rel_ack", 32'(rel_ack), 1); chk("R9", "gnt", 32'(gnt), 0);
    chk("R4", "oe_rel", 32'(oe), 0);
    step(); chk("R9", "rel_ack_hold", 32'(rel_ack), 1);
    rel = 1'b0; step();
    chk("R9", "oe_back", 32'(oe), 1); chk("R9", "hold_off", 32'(hold), 0);

    // seeded random traffic
    void'($urandom(32'd20240917));
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 9) == 0) req = ~req;
      busy = $urandom_range(0, 1) == 1;
      ack  = $urandom_range(0, 3) == 0;
      if ($urandom_range(0, 7) == 0) rel = ~rel;
      strb = $urandom_range(0, 1) == 1;
      addr = AW'($urandom);
      step();
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule